// File: doc/BRIEF.md
# Synthesizer Command Register Bank

This block sits behind a serial receiver in a direct digital synthesizer. Each cycle that `cmd_valid` is high, it takes one 16-bit command word and decodes the word's two top bits as a destination. The destination is the control register, one of two 28-bit tuning registers, or one of two 12-bit phase-offset registers. The tuning and phase registers, and the decoded control fields, are presented continuously to the oscillator datapath.

Tuning writes carry 14 payload bits, so a 28-bit tuning word needs help from the control register. In full-word mode, a pair of back-to-back writes to the same tuning register delivers the low half and then the high half. The low half waits in a pending holder, and the register is replaced in one step when the high half arrives. In split mode, each tuning write replaces one half only, and a half-select bit chooses which half.

Top module: `dds_regbank`

## Requirements
- R1: Word bits 15:14 pick the destination: 00 control register, 01 tuning register 0, 10 tuning register 1, 11 phase bank. A write takes effect at the clock edge where `cmd_valid` is sampled high, and the outputs show it from that edge on.
- R2: A phase write stores bits 11:0 into phase register 0 when bit 13 is 0, or into phase register 1 when bit 13 is 1. Bit 12 has no effect, and the other phase register keeps its value.
- R3: With control bit 13 set (full-word mode), two consecutive tuning writes to the same register load it with {second write bits 13:0, first write bits 13:0}.
- R4: In full-word mode, the first write of a pair leaves the tuning register unchanged, so it never holds a mix of old and new halves.
- R5: With control bit 13 clear (split mode), a tuning write replaces bits 27:14 when control bit 12 is 1, or bits 13:0 when it is 0. The other half is kept.
- R6: In full-word mode, control bit 12 has no effect on how a pair is assembled.
- R7: A pending low half is dropped when the next write is a control write, a phase write, or a tuning write to the other register. A tuning write to the other register then becomes the first half of a new pair.
- R8: The decoded outputs follow control bits 11 (tuning select), 10 (phase select), 8 (core reset), 7 (clock halt), 6 (converter power-down), 5 (bit output enable), 3 (divide-by-two select), 1 (ramp mode), 13 (full-word mode) and 12 (upper half select).
- R9: Setting the core-reset control bit does not clear the tuning, phase or control registers.
- R10: While `rst_n` is low, every register and every decoded output is zero, and no low half is pending.
- R11: While `cmd_valid` is low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word strobe |
| cmd_word | input | 16 | Command word |
| freq0_q | output | 28 | Tuning register 0 |
| freq1_q | output | 28 | Tuning register 1 |
| phase0_q | output | 12 | Phase register 0 |
| phase1_q | output | 12 | Phase register 1 |
| fsel | output | 1 | Tuning register select |
| psel | output | 1 | Phase register select |
| core_rst | output | 1 | Oscillator core reset |
| clk_halt | output | 1 | Internal clock halt |
| dac_pd | output | 1 | Converter power-down |
| bit_out_en | output | 1 | Digital bit output enable |
| div2_sel | output | 1 | Divide-by-two select |
| ramp_mode | output | 1 | Ramp (table bypass) mode |
| full_mode | output | 1 | Full-word tuning mode |
| upper_sel | output | 1 | Upper half select in split mode |

## Verification
Directed sequences cover the main cases of the tuning path:
- A clean low/high pair tells assembly order apart from a swapped order.
- A first half alone tells atomic loading apart from early update.
- A pair interrupted by a control write, a phase write or a write to the other register tells discarding apart from stale reuse of the pending half.
- Split writes in both halves, with payloads that differ per half, expose a wrong half select.

Seeded random words with biased destination bits then mix modes at arbitrary points, including mode changes in the middle of a pair. A bench model compares every register after each word.

// File: rtl/dds_regbank_pkg.sv
package dds_regbank_pkg;

  typedef enum logic [1:0] {
    DST_CTRL  = 2'b00,
    DST_TUNE0 = 2'b01,
    DST_TUNE1 = 2'b10,
    DST_PHASE = 2'b11
  } dst_e;

  localparam int B_FULL   = 13;
  localparam int B_UPPER  = 12;
  localparam int B_FSEL   = 11;
  localparam int B_PSEL   = 10;
  localparam int B_CRST   = 8;
  localparam int B_HALT   = 7;
  localparam int B_DACPD  = 6;
  localparam int B_BITOUT = 5;
  localparam int B_DIV2   = 3;
  localparam int B_RAMP   = 1;
  localparam int B_PHSEL  = 13;

  typedef struct packed {
    logic full;
    logic upper;
    logic fsel;
    logic psel;
    logic crst;
    logic halt;
    logic dacpd;
    logic bitout;
    logic div2;
    logic ramp;
  } ctrl_fields_t;

  function automatic ctrl_fields_t split_ctrl(input logic [15:0] w);
    ctrl_fields_t f;
    f.full   = w[B_FULL];
    f.upper  = w[B_UPPER];
    f.fsel   = w[B_FSEL];
    f.psel   = w[B_PSEL];
    f.crst   = w[B_CRST];
    f.halt   = w[B_HALT];
    f.dacpd  = w[B_DACPD];
    f.bitout = w[B_BITOUT];
    f.div2   = w[B_DIV2];
    f.ramp   = w[B_RAMP];
    return f;
  endfunction

endpackage

// File: rtl/dds_cmd_decode.sv
module dds_cmd_decode
  import dds_regbank_pkg::*;
#(
  parameter int CMD_W     = 16,
  parameter int NUM_TUNE  = 2,
  parameter int NUM_PHASE = 2
) (
  input  logic                 valid,
  input  logic [CMD_W-1:0]     word,
  output logic                 ctrl_wr,
  output logic [NUM_TUNE-1:0]  tune_wr,
  output logic [NUM_PHASE-1:0] phase_wr
);
  localparam int DST_HI = CMD_W - 1;
  localparam int DST_LO = CMD_W - 2;

  dst_e dst;
  assign dst = dst_e'(word[DST_HI:DST_LO]);

  always_comb begin
    ctrl_wr  = valid && (dst == DST_CTRL);
    tune_wr  = '0;
    phase_wr = '0;
    if (valid && dst == DST_TUNE0) tune_wr[0] = 1'b1;
    if (valid && dst == DST_TUNE1) tune_wr[NUM_TUNE-1] = 1'b1;
    if (valid && dst == DST_PHASE) phase_wr[word[B_PHSEL]] = 1'b1;
  end
endmodule

// File: rtl/dds_phase_bank.sv
module dds_phase_bank #(
  parameter int PHASE_W   = 12,
  parameter int NUM_PHASE = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PHASE-1:0] phase_wr,
  input  logic [PHASE_W-1:0]   data,
  output logic [PHASE_W-1:0]   phase_q [NUM_PHASE]
);
  for (genvar g = 0; g < NUM_PHASE; g++) begin : g_ph
    always_ff @(posedge clk) begin
      if (!rst_n)           phase_q[g] <= '0;
      else if (phase_wr[g]) phase_q[g] <= data;
    end
  end
endmodule

// File: rtl/dds_tune_loader.sv
module dds_tune_loader #(
  parameter int FREQ_W   = 28,
  parameter int NUM_TUNE = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_TUNE-1:0] tune_wr,
  input  logic                other_wr,
  input  logic [FREQ_W/2-1:0] data,
  input  logic                full_mode,
  input  logic                upper_sel,
  output logic [FREQ_W-1:0]   tune_q [NUM_TUNE],
  output logic                pend_valid,
  output logic [$clog2(NUM_TUNE)-1:0] pend_tgt,
  output logic [FREQ_W/2-1:0] pend_half,
  output logic                first_evt,
  output logic                commit_evt
);
  localparam int HALF_W = FREQ_W / 2;
  localparam int IDX_W  = $clog2(NUM_TUNE);

  function automatic logic [FREQ_W-1:0] patch_half(input logic [FREQ_W-1:0] old,
                                                   input logic [HALF_W-1:0] nib,
                                                   input logic hi);
    return hi ? {nib, old[HALF_W-1:0]} : {old[FREQ_W-1:HALF_W], nib};
  endfunction

  function automatic logic [FREQ_W-1:0] join_pair(input logic [HALF_W-1:0] hi_part,
                                                  input logic [HALF_W-1:0] lo_part);
    return {hi_part, lo_part};
  endfunction

  logic             wr_any;
  logic [IDX_W-1:0] wr_idx;
  logic             tgt_match;

  always_comb begin
    wr_any = |tune_wr;
    wr_idx = '0;
    for (int i = 0; i < NUM_TUNE; i++)
      if (tune_wr[i]) wr_idx = IDX_W'(i);
    tgt_match  = pend_valid && (pend_tgt == wr_idx);
    first_evt  = wr_any && full_mode && !tgt_match;
    commit_evt = wr_any && full_mode && tgt_match;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_tgt   <= '0;
      pend_half  <= '0;
    end else if (first_evt) begin
      pend_valid <= 1'b1;
      pend_tgt   <= wr_idx;
      pend_half  <= data;
    end else if (wr_any || other_wr) begin
      pend_valid <= 1'b0;
    end
  end

  for (genvar g = 0; g < NUM_TUNE; g++) begin : g_tune
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tune_q[g] <= '0;
      end else if (tune_wr[g]) begin
        if (!full_mode)      tune_q[g] <= patch_half(tune_q[g], data, upper_sel);
        else if (commit_evt) tune_q[g] <= join_pair(data, pend_half);
      end
    end
  end
endmodule

// File: rtl/dds_regbank.sv
module dds_regbank
  import dds_regbank_pkg::*;
#(
  parameter int CMD_W   = 16,
  parameter int FREQ_W  = 28,
  parameter int PHASE_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [CMD_W-1:0]   cmd_word,
  output logic [FREQ_W-1:0]  freq0_q,
  output logic [FREQ_W-1:0]  freq1_q,
  output logic [PHASE_W-1:0] phase0_q,
  output logic [PHASE_W-1:0] phase1_q,
  output logic               fsel,
  output logic               psel,
  output logic               core_rst,
  output logic               clk_halt,
  output logic               dac_pd,
  output logic               bit_out_en,
  output logic               div2_sel,
  output logic               ramp_mode,
  output logic               full_mode,
  output logic               upper_sel
);
  localparam int NUM_TUNE  = 2;
  localparam int NUM_PHASE = 2;
  localparam int HALF_W    = FREQ_W / 2;

  logic                 ctrl_wr;
  logic [NUM_TUNE-1:0]  tune_wr;
  logic [NUM_PHASE-1:0] phase_wr;
  logic [CMD_W-1:0]     ctrl_q;
  ctrl_fields_t         cf;
  logic [FREQ_W-1:0]    tune_q  [NUM_TUNE];
  logic [PHASE_W-1:0]   phase_q [NUM_PHASE];
  logic                 pend_valid;
  logic [$clog2(NUM_TUNE)-1:0] pend_tgt;
  logic [HALF_W-1:0]    pend_half;
  logic                 first_evt;
  logic                 commit_evt;

  dds_cmd_decode #(.CMD_W(CMD_W), .NUM_TUNE(NUM_TUNE), .NUM_PHASE(NUM_PHASE)) u_dec (
    .valid(cmd_valid), .word(cmd_word),
    .ctrl_wr(ctrl_wr), .tune_wr(tune_wr), .phase_wr(phase_wr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= cmd_word;
  end

  assign cf = split_ctrl(ctrl_q[15:0]);

  dds_tune_loader #(.FREQ_W(FREQ_W), .NUM_TUNE(NUM_TUNE)) u_tune (
    .clk(clk), .rst_n(rst_n),
    .tune_wr(tune_wr), .other_wr(ctrl_wr || (|phase_wr)),
    .data(cmd_word[HALF_W-1:0]),
    .full_mode(cf.full), .upper_sel(cf.upper),
    .tune_q(tune_q),
    .pend_valid(pend_valid), .pend_tgt(pend_tgt), .pend_half(pend_half),
    .first_evt(first_evt), .commit_evt(commit_evt)
  );

  dds_phase_bank #(.PHASE_W(PHASE_W), .NUM_PHASE(NUM_PHASE)) u_phase (
    .clk(clk), .rst_n(rst_n),
    .phase_wr(phase_wr), .data(cmd_word[PHASE_W-1:0]),
    .phase_q(phase_q)
  );

  assign freq0_q    = tune_q[0];
  assign freq1_q    = tune_q[1];
  assign phase0_q   = phase_q[0];
  assign phase1_q   = phase_q[1];
  assign fsel       = cf.fsel;
  assign psel       = cf.psel;
  assign core_rst   = cf.crst;
  assign clk_halt   = cf.halt;
  assign dac_pd     = cf.dacpd;
  assign bit_out_en = cf.bitout;
  assign div2_sel   = cf.div2;
  assign ramp_mode  = cf.ramp;
  assign full_mode  = cf.full;
  assign upper_sel  = cf.upper;
endmodule

// File: rtl/dds_regbank_chk.sv
module dds_regbank_chk #(
  parameter int CMD_W   = 16,
  parameter int FREQ_W  = 28,
  parameter int PHASE_W = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic [CMD_W-1:0]   cmd_word,
  input logic [FREQ_W-1:0]  freq0_q,
  input logic [FREQ_W-1:0]  freq1_q,
  input logic [PHASE_W-1:0] phase0_q,
  input logic [PHASE_W-1:0] phase1_q,
  input logic               full_mode,
  input logic               upper_sel,
  input logic               pend_valid,
  input logic               pend_tgt,
  input logic [FREQ_W/2-1:0] pend_half
);
  localparam int HALF_W = FREQ_W / 2;
  logic [1:0] dst;
  assign dst = cmd_word[CMD_W-1:CMD_W-2];

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(freq0_q) && $stable(freq1_q) && $stable(phase0_q) && $stable(phase1_q));

  // R4
  first_half_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && dst == 2'b01 && full_mode && !(pend_valid && pend_tgt == 1'b0)) |=> $stable(freq0_q));

  // R3
  pair_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && dst == 2'b10 && full_mode && pend_valid && pend_tgt == 1'b1)
      |=> freq1_q == {$past(cmd_word[HALF_W-1:0]), $past(pend_half)});

  // R7
  pend_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (dst == 2'b00 || dst == 2'b11)) |=> !pend_valid);

  // R2
  phase0_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && dst == 2'b11 && !cmd_word[13])
      |=> phase0_q == $past(cmd_word[PHASE_W-1:0]) && $stable(phase1_q));

  // R5
  split_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && dst == 2'b01 && !full_mode && upper_sel)
      |=> freq0_q[HALF_W-1:0] == $past(freq0_q[HALF_W-1:0])
          && freq0_q[FREQ_W-1:HALF_W] == $past(cmd_word[HALF_W-1:0]));
endmodule

bind dds_regbank dds_regbank_chk #(.CMD_W(CMD_W), .FREQ_W(FREQ_W), .PHASE_W(PHASE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
  .freq0_q(freq0_q), .freq1_q(freq1_q), .phase0_q(phase0_q), .phase1_q(phase1_q),
  .full_mode(full_mode), .upper_sel(upper_sel),
  .pend_valid(pend_valid), .pend_tgt(pend_tgt), .pend_half(pend_half)
);

// File: tb/tb_dds_regbank.sv
module tb_dds_regbank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [15:0] cmd_word = '0;
  logic [27:0] freq0_q, freq1_q;
  logic [11:0] phase0_q, phase1_q;
  logic fsel, psel, core_rst, clk_halt, dac_pd, bit_out_en, div2_sel, ramp_mode, full_mode, upper_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench-side register image
  logic [15:0] m_ctrl;
  logic [27:0] m_f [2];
  logic [11:0] m_p [2];
  bit          m_pv;
  int          m_pt;
  logic [13:0] m_pl;

  always #5 clk = ~clk;

  dds_regbank dut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [27:0] set_half(input logic [27:0] v, input logic [13:0] n, input bit hi);
    logic [27:0] r = v;
    if (hi) r[27:14] = n; else r[13:0] = n;
    return r;
  endfunction

  task automatic model_apply(input logic [15:0] w);
    int t;
    case (w[15:14])
      2'b00: begin m_ctrl = w; m_pv = 0; end
      2'b11: begin m_p[w[13]] = w[11:0]; m_pv = 0; end
      default: begin
        t = (w[15:14] == 2'b01) ? 0 : 1;
        if (!m_ctrl[13]) begin
          m_f[t] = set_half(m_f[t], w[13:0], m_ctrl[12]);
          m_pv = 0;
        end else if (m_pv && m_pt == t) begin
          m_f[t] = {w[13:0], m_pl};
          m_pv = 0;
        end else begin
          m_pv = 1; m_pt = t; m_pl = w[13:0];
        end
      end
    endcase
  endtask

  task automatic compare_all(input string tag);
    check({tag, " freq0"}, {4'h0, freq0_q}, {4'h0, m_f[0]});
    check({tag, " freq1"}, {4'h0, freq1_q}, {4'h0, m_f[1]});
    check({tag, " phase0"}, {20'h0, phase0_q}, {20'h0, m_p[0]});
    check({tag, " phase1"}, {20'h0, phase1_q}, {20'h0, m_p[1]});
    // R8 field positions
    check({tag, " R8 fields"},
          {22'h0, full_mode, upper_sel, fsel, psel, core_rst, clk_halt, dac_pd, bit_out_en, div2_sel, ramp_mode},
          {22'h0, m_ctrl[13], m_ctrl[12], m_ctrl[11], m_ctrl[10], m_ctrl[8], m_ctrl[7],
           m_ctrl[6], m_ctrl[5], m_ctrl[3], m_ctrl[1]});
  endtask

  task automatic send(input logic [15:0] w, input string tag);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = w;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_word  = $urandom;  // ignored while strobe is low
    model_apply(w);
    compare_all(tag);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_ctrl = '0; m_f[0] = '0; m_f[1] = '0; m_p[0] = '0; m_p[1] = '0;
    m_pv = 0; m_pt = 0; m_pl = '0;
    repeat (3) @(negedge clk);
    compare_all("R10 reset");
    rst_n = 1'b1;

    // R1 control write, field decode
    send(16'h0FEA, "R1 ctrl");
    send(16'h0000, "R1 ctrl clear");
    // R5 split mode, low then high
    send(16'h0000, "R5 lo mode");
    send(16'h4123, "R5 lo f0");
    send(16'h1000, "R5 hi mode");
    send(16'h8ABC, "R5 hi f1");
    send(16'h7FFF, "R5 hi f0");
    // R3/R4 full-word pair
    send(16'h2000, "R3 mode");
    send(16'h4555, "R4 first half");
    send(16'h4AAA, "R3 commit");
    // R6 upper select ignored in full mode
    send(16'h3000, "R6 mode");
    send(16'h8111, "R6 first");
    send(16'h8222, "R6 commit");
    // R7 interrupted by other target
    send(16'h4333, "R7 first f0");
    send(16'h8444, "R7 retarget f1");
    send(16'h8666, "R7 commit f1");
    // R7 interrupted by phase write
    send(16'h4777, "R7 first");
    send(16'hC123, "R7 phase");
    send(16'h4888, "R7 new first");
    send(16'h4999, "R7 commit after phase");
    // R7 interrupted by control write
    send(16'h4AAA, "R7 first");
    send(16'h2000, "R7 ctrl");
    send(16'h4BBB, "R7 new first");
    send(16'h4CCC, "R7 commit after ctrl");
    // R2 phase bank, bit 12 ignored
    send(16'hD456, "R2 ph0 b12");
    send(16'hE789, "R2 ph1");
    send(16'hF0F0, "R2 ph1 b12");
    // R9 core reset keeps registers
    send(16'h2100, "R9 core reset");
    send(16'h2000, "R9 release");
    // R11 idle cycles
    repeat (5) @(negedge clk);
    compare_all("R11 idle");

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [15:0] w = 16'($urandom);
      if ($urandom_range(0, 3) == 0) w[15:14] = 2'b00;
      send(w, "R1 random");
      if ($urandom_range(0, 7) == 0) begin
        repeat ($urandom_range(1, 3)) @(negedge clk);
        compare_all("R11 random idle");
      end
    end

    // R10 reset again
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    m_ctrl = '0; m_f[0] = '0; m_f[1] = '0; m_p[0] = '0; m_p[1] = '0; m_pv = 0;
    compare_all("R10 rereset");
    rst_n = 1'b1;
    send(16'h2000, "R10 mode");
    send(16'h8001, "R10 no stale pend");
    check("R10 pending cleared", {4'h0, freq1_q}, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule